// File: doc/BRIEF.md
# GPIO Bank with Event Detection

A bank of up to 32 general-purpose pins under one simple register port. Each pin has a direction bit, an output data bit and a readable input value. Each pin also has four detection enables: low level, high level, rising edge and falling edge. Any combination of these may be set on a pin. The pin inputs arrive already synchronised to `clk`, and the block does no debouncing.

Every detected event sets a sticky status bit for its pin. Software clears a status bit by writing 1 to it. Status bits that are also set in the interrupt-enable register drive the single `irq` line. A control bit gates the whole bank off from detecting events. A per-pin wake-up enable is changed through separate set and clear addresses. A global enable bit turns these wake-up enables into a `wake_req` pulse.

The register port uses word addresses. A write takes effect at the clock edge where `bus_we` is high. Read data is combinational from `bus_addr`.

Top module: `gpio_event_bank`

## Requirements
- R1: After reset, direction (addr 2) reads all ones, and output data (addr 3), status (addr 9), control (addr 1) and wake-up configuration (addr 0) read 0. `pin_oe_n` is all ones, and `pin_out`, `irq` and `wake_req` are 0.
- R2: The direction register (addr 2) drives `pin_oe_n` bit for bit, where 1 means input and 0 means drive, and it reads back the written value.
- R3: The output data register (addr 3) drives `pin_out` and reads back the last written value. Addr 4 returns `pin_in` whatever the direction setting.
- R4: A pin enabled in the low-level register (addr 5) sets its status bit at every edge where it is sampled 0. A pin enabled in the high-level register (addr 6) does the same when it is sampled 1. The bit is readable the cycle after.
- R5: A pin enabled in the rising register (addr 7) sets status only when it is sampled 1 and was 0 at the previous edge. A steady high sets nothing.
- R6: A pin enabled in the falling register (addr 8) sets status on a 1-to-0 change. With both the rising and falling enables set, either change sets status.
- R7: Status bits (addr 9) are sticky. Writing 1 clears a bit and writing 0 leaves it unchanged. An event in the same cycle as the clear keeps the bit set.
- R8: `irq` is high exactly when some status bit is set whose bit in the interrupt-enable register (addr 10) is 1.
- R9: While bit 0 of control (addr 1) is 1, no status bit becomes newly set, and existing status is kept. Detection resumes when the bit returns to 0.
- R10: Writing 1s to addr 12 sets wake-up enable bits, and writing 1s to addr 13 clears them. Bits written 0 to either address are unchanged. Addr 11 reads the enables.
- R11: `wake_req` is high for the cycle after an edge that detected an event on a wake-enabled pin, but only while bit 2 of addr 0 is 1. It is otherwise 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | N_PINS | Synchronised pin levels |
| pin_out | output | N_PINS | Output data to the pads |
| pin_oe_n | output | N_PINS | Active-low drive enable (1 = input) |
| irq | output | 1 | Masked event interrupt |
| wake_req | output | 1 | Wake-up request |

## Verification
The assertions check on every cycle that status bits stay set unless a clear write arrives, and that a gated bank sets no new status. They also check that `irq` never rises without a status bit behind it, that `wake_req` stays low while the global wake bit is off, and that the set alias really sets the bits it names. Only the bench scenarios can show which detection mode reacts to which input sequence. They also cover the exact one-cycle timing of an edge against a steady level, the clear-versus-event race, and the read-back of each register.

// File: rtl/gpio_event_bank.sv
module gpio_event_bank #(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe_n,
  output logic              irq,
  output logic              wake_req
);
  localparam logic [ADDR_W-1:0] A_SYS  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_LLO  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_LHI  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_RISE = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_FALL = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] A_WEN  = ADDR_W'(11);
  localparam logic [ADDR_W-1:0] A_WSET = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_WCLR = ADDR_W'(13);
  localparam int WAKE_BIT = 2;

  logic              sys_wake_q, gate_q, wake_req_q;
  logic [N_PINS-1:0] dir_q, dout_q, llo_q, lhi_q, rise_q, fall_q;
  logic [N_PINS-1:0] status_q, ien_q, wen_q, prev_q, evt;
  logic [N_PINS-1:0] wd;

  assign wd = bus_wdata[N_PINS-1:0];

  assign evt = gate_q ? '0 :
      ((llo_q & ~pin_in) | (lhi_q & pin_in) |
       (rise_q & pin_in & ~prev_q) | (fall_q & ~pin_in & prev_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_wake_q <= 1'b0;
      gate_q     <= 1'b0;
      dir_q      <= '1;
      dout_q     <= '0;
      llo_q      <= '0;
      lhi_q      <= '0;
      rise_q     <= '0;
      fall_q     <= '0;
      ien_q      <= '0;
      wen_q      <= '0;
      status_q   <= '0;
      prev_q     <= '0;
      wake_req_q <= 1'b0;
    end else begin
      prev_q     <= pin_in;
      status_q   <= (status_q & ~((bus_we && bus_addr == A_STAT) ? wd : '0)) | evt;
      wake_req_q <= sys_wake_q & (|(evt & wen_q));
      if (bus_we) begin
        case (bus_addr)
          A_SYS:  sys_wake_q <= bus_wdata[WAKE_BIT];
          A_GATE: gate_q     <= bus_wdata[0];
          A_DIR:  dir_q      <= wd;
          A_DOUT: dout_q     <= wd;
          A_LLO:  llo_q      <= wd;
          A_LHI:  lhi_q      <= wd;
          A_RISE: rise_q     <= wd;
          A_FALL: fall_q     <= wd;
          A_IEN:  ien_q      <= wd;
          A_WSET: wen_q      <= wen_q | wd;
          A_WCLR: wen_q      <= wen_q & ~wd;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_SYS:  bus_rdata[WAKE_BIT]   = sys_wake_q;
      A_GATE: bus_rdata[0]          = gate_q;
      A_DIR:  bus_rdata[N_PINS-1:0] = dir_q;
      A_DOUT: bus_rdata[N_PINS-1:0] = dout_q;
      A_DIN:  bus_rdata[N_PINS-1:0] = pin_in;
      A_LLO:  bus_rdata[N_PINS-1:0] = llo_q;
      A_LHI:  bus_rdata[N_PINS-1:0] = lhi_q;
      A_RISE: bus_rdata[N_PINS-1:0] = rise_q;
      A_FALL: bus_rdata[N_PINS-1:0] = fall_q;
      A_STAT: bus_rdata[N_PINS-1:0] = status_q;
      A_IEN:  bus_rdata[N_PINS-1:0] = ien_q;
      A_WEN:  bus_rdata[N_PINS-1:0] = wen_q;
      default: ;
    endcase
  end

  assign pin_out  = dout_q;
  assign pin_oe_n = dir_q;
  assign irq      = |(status_q & ien_q);
  assign wake_req = wake_req_q;
endmodule

// File: rtl/gpio_event_bank_chk.sv
module gpio_event_bank_chk #(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [N_PINS-1:0] status_q,
  input logic [N_PINS-1:0] wen_q,
  input logic              gate_q,
  input logic              sys_wake_q,
  input logic              irq,
  input logic              wake_req
);
  localparam logic [ADDR_W-1:0] C_STAT = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] C_WSET = ADDR_W'(12);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == C_STAT) |=> ((status_q & $past(status_q)) == $past(status_q)));

  a_r9_gate_holds: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |=> ((status_q & ~$past(status_q)) == '0));

  a_r8_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_q != '0));

  a_r11_wake_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_wake_q |=> !wake_req);

  a_r10_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == C_WSET) |=>
      ((wen_q & $past(bus_wdata[N_PINS-1:0])) == $past(bus_wdata[N_PINS-1:0])));
endmodule

bind gpio_event_bank gpio_event_bank_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .status_q(status_q), .wen_q(wen_q), .gate_q(gate_q),
  .sys_wake_q(sys_wake_q), .irq(irq), .wake_req(wake_req)
);

// File: tb/gpio_event_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_event_bank_tb_top;
  localparam int N = 32;
  localparam int AW = 4;
  localparam int K_RD = 0, K_IRQ = 1, K_WAKE = 2, K_OUT = 3, K_OEN = 4;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out, pin_oe_n;
  logic          irq, wake_req;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  item_t sb_q[$];

  always #2 clk = ~clk;

  gpio_event_bank #(.N_PINS(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe_n(pin_oe_n), .irq(irq), .wake_req(wake_req)
  );

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        K_RD:    act = bus_rdata;
        K_IRQ:   act = {31'd0, irq};
        K_WAKE:  act = {31'd0, wake_req};
        K_OUT:   act = pin_out;
        default: act = pin_oe_n;
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic expect_item(input int kind, input int a, input logic [31:0] e, input string tag);
    item_t it;
    bus_addr = AW'(a);
    it.kind = kind; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    expect_item(K_RD, 2, 32'hFFFF_FFFF, "R1 dir reset");
    expect_item(K_RD, 9, 32'h0, "R1 status reset");
    expect_item(K_RD, 1, 32'h0, "R1 control reset");
    expect_item(K_OEN, 0, 32'hFFFF_FFFF, "R1 oe_n reset");
    expect_item(K_OUT, 0, 32'h0, "R1 pin_out reset");
    expect_item(K_IRQ, 0, 32'h0, "R1 irq reset");
    expect_item(K_WAKE, 0, 32'h0, "R1 wake reset");
    // R2 direction
    wr(2, 32'h0000_FF00);
    expect_item(K_OEN, 2, 32'h0000_FF00, "R2 oe_n");
    expect_item(K_RD, 2, 32'h0000_FF00, "R2 readback");
    // R3 data
    wr(3, 32'hA5A5_0F0F);
    expect_item(K_OUT, 3, 32'hA5A5_0F0F, "R3 pin_out");
    expect_item(K_RD, 3, 32'hA5A5_0F0F, "R3 dout readback");
    pin_in = 32'h1234_5678;
    expect_item(K_RD, 4, 32'h1234_5678, "R3 din");
    pin_in = '0;
    tick();
    // R4 low and high level
    wr(5, 32'h1);
    tick();
    expect_item(K_RD, 9, 32'h1, "R4 low level");
    wr(5, 32'h0);
    wr(9, 32'h1);
    expect_item(K_RD, 9, 32'h0, "R7 clear");
    pin_in = 32'h2;
    wr(6, 32'h2);
    tick();
    expect_item(K_RD, 9, 32'h2, "R4 high level");
    wr(9, 32'h2);
    expect_item(K_RD, 9, 32'h2, "R7 event wins over clear");
    wr(6, 32'h0);
    wr(9, 32'h2);
    expect_item(K_RD, 9, 32'h0, "R7 clear after disable");
    // R5 rising
    wr(7, 32'h10);
    tick();
    expect_item(K_RD, 9, 32'h0, "R5 no edge");
    pin_in = 32'h12;
    tick();
    expect_item(K_RD, 9, 32'h10, "R5 rising");
    wr(9, 32'h10);
    tick(); tick();
    expect_item(K_RD, 9, 32'h0, "R5 steady high");
    // R6 falling and both
    wr(8, 32'h10);
    pin_in = 32'h02;
    tick();
    expect_item(K_RD, 9, 32'h10, "R6 both falling");
    wr(9, 32'h10);
    pin_in = 32'h12;
    tick();
    expect_item(K_RD, 9, 32'h10, "R6 both rising");
    wr(9, 32'h10);
    wr(7, 32'h0);
    pin_in = 32'h02;
    tick();
    expect_item(K_RD, 9, 32'h10, "R6 falling only");
    wr(9, 32'h10);
    pin_in = 32'h12;
    tick();
    expect_item(K_RD, 9, 32'h0, "R6 rise ignored");
    wr(8, 32'h0);
    // R7 partial clear
    wr(6, 32'h12);
    wr(6, 32'h0);
    wr(9, 32'h02);
    expect_item(K_RD, 9, 32'h10, "R7 partial clear");
    // R8 irq
    wr(10, 32'h1);
    expect_item(K_IRQ, 0, 32'h0, "R8 masked");
    wr(10, 32'h10);
    expect_item(K_IRQ, 0, 32'h1, "R8 enabled");
    wr(9, 32'h10);
    expect_item(K_IRQ, 0, 32'h0, "R8 cleared");
    // R9 gating
    wr(1, 32'h1);
    expect_item(K_RD, 1, 32'h1, "R9 gate readback");
    wr(5, 32'h100);
    tick(); tick();
    expect_item(K_RD, 9, 32'h0, "R9 gated");
    wr(1, 32'h0);
    tick();
    expect_item(K_RD, 9, 32'h100, "R9 resumed");
    wr(5, 32'h0);
    wr(9, 32'h100);
    // R10 wake aliases
    wr(12, 32'h300);
    expect_item(K_RD, 11, 32'h300, "R10 set");
    wr(12, 32'h1);
    expect_item(K_RD, 11, 32'h301, "R10 set keeps others");
    wr(13, 32'h100);
    expect_item(K_RD, 11, 32'h201, "R10 clear");
    // R11 wake request
    wr(0, 32'h4);
    expect_item(K_RD, 0, 32'h4, "R11 global readback");
    wr(7, 32'h1);
    pin_in = 32'h13;
    tick();
    expect_item(K_WAKE, 0, 32'h1, "R11 wake pulse");
    tick();
    expect_item(K_WAKE, 0, 32'h0, "R11 pulse ends");
    wr(0, 32'h0);
    pin_in = 32'h12;
    tick();
    pin_in = 32'h13;
    tick();
    expect_item(K_WAKE, 0, 32'h0, "R11 globally off");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule